// File: doc/BRIEF.md
# Acknowledged Link Frame Transmitter with Replay

This block turns 72-bit payload words into fixed 80-bit link frames and emits one frame in every clock cycle (one frame slot) toward a serializer. Each frame carries a flag that tells data frames from link-control frames, one bit that passes back acknowledges from the local receiver, and a 6-bit CRC. Every data frame sent is held in a replay store until the far end acknowledges it. Acknowledges arrive as single-cycle pulses, and each pulse retires the oldest held frame.

Recovery relies on positive acknowledges only. When frames are outstanding and no acknowledge arrives for a fixed number of slots, the block sends a Replay control frame and then resends every held frame, oldest first. New payload is refused during that resend. When there is nothing to send, the slot carries a Pause control frame.

Top module: `frame_tx_replay`

## Requirements
- R1: While reset is high, `frame_o` holds a Pause frame with the acknowledge bit clear and a valid CRC, and `pay_ready_o` is high.
- R2: A frame is laid out as payload in bits 79:8, the link-control flag in bit 7 (0 for data, 1 for link control), the acknowledge bit in bit 6 and the CRC in bits 5:0. An accepted payload word appears as a data frame in the slot registered on the accepting clock edge.
- R3: The CRC is CRC-6 with polynomial x^6+x+1 (0x03), seed 0x3F and no final inversion. It is computed over bits 79:6, most significant bit first.
- R4: In a link-control frame, payload bits 79:72 hold the operation code (0x00 Pause, 0x01 Replay) and payload bits 71:8 are zero.
- R5: In a slot with no accepted payload and no replay activity, the block sends a Pause frame.
- R6: The acknowledge bit of each frame equals `loc_ack_i` on the clock edge that registers the frame, and it is covered by the CRC.
- R7: The replay store holds 16 frames. Once 16 are outstanding, `pay_ready_o` is low and no further payload is accepted.
- R8: Each `far_ack_i` pulse retires the oldest held frame and frees one place. A pulse with nothing outstanding is ignored and does not reduce the later capacity.
- R9: If frames are outstanding and 64 consecutive slots pass with no acknowledge, the next slot carries a Replay frame. The held frames follow in the order they were first sent, and normal operation then resumes.
- R10: `pay_ready_o` is low from the slot that starts a replay until the last held frame has been resent. Payload offered meanwhile is sent after the resent frames.
- R11: Each acknowledge restarts the 64-slot stall count, so a replay after an acknowledge comes only 64 silent slots later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one frame slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pay_valid_i | input | 1 | Payload word offered |
| pay_ready_o | output | 1 | Payload word will be taken on this edge |
| pay_data_i | input | 72 | Payload word |
| far_ack_i | input | 1 | One-cycle pulse: the far end acknowledged the oldest frame |
| loc_ack_i | input | 1 | Acknowledge from the local receiver, placed in the outgoing frame |
| frame_o | output | 80 | Registered frame toward the serializer |

## Verification
The bench builds the block with its default sizes: a store depth of 16 and a stall limit of 64 slots. At these sizes the store can be filled to the limit and drained by hand, and a full stall-to-replay interval fits in under a hundred cycles, so the exact slot of the Replay frame is checked both from a push and from an acknowledge. Expected frames, including every CRC, come from a bit-serial CRC model in the bench, applied over a sweep of single-bit-shifted payload patterns with the acknowledge bit toggling.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    localparam int PAY_W   = 72;
    localparam int CRC_W   = 6;
    localparam int OP_W    = 8;
    localparam int FRAME_W = PAY_W + 2 + CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 6'h03;
    localparam logic [CRC_W-1:0] CRC_SEED = 6'h3F;

    typedef enum logic [OP_W-1:0] {
        OP_PAUSE  = 8'h00,
        OP_REPLAY = 8'h01
    } link_op_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_MARK,
        RP_RESEND
    } rp_state_e;

    typedef struct packed {
        logic [PAY_W-1:0] payload;
        logic             is_link;
        logic             ack;
        logic [CRC_W-1:0] crc;
    } frame_t;

    // Bit-serial CRC over payload plus the two control bits, MSB first.
    function automatic logic [CRC_W-1:0] crc_calc(input logic [PAY_W+1:0] bits);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = CRC_SEED;
        for (int i = PAY_W + 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ bits[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic logic [PAY_W-1:0] link_word(input link_op_e op);
        return {op, {(PAY_W-OP_W){1'b0}}};
    endfunction

    function automatic frame_t make_frame(input logic [PAY_W-1:0] pay,
                                          input logic is_link,
                                          input logic ack);
        frame_t f;
        f.payload = pay;
        f.is_link = is_link;
        f.ack     = ack;
        f.crc     = crc_calc({pay, is_link, ack});
        return f;
    endfunction

endpackage

// File: rtl/replay_store.sv
module replay_store
    import frame_tx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [PAY_W-1:0] push_data_i,
    input  logic             retire_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [PAY_W-1:0] rd_data_o,
    output logic [PTR_W-1:0] head_o,
    output logic [OCC_W-1:0] occ_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PAY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q;
    logic             do_retire;

    assign do_retire = retire_i && (occ_q != '0);

    always_ff @(posedge clk) begin
        if (push_i) mem[tail_q] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (push_i)    tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
            if (do_retire) head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
            if (push_i && !do_retire)      occ_q <= occ_q + 1'b1;
            else if (!push_i && do_retire) occ_q <= occ_q - 1'b1;
        end
    end

    assign rd_data_o = mem[rd_idx_i];
    assign head_o    = head_q;
    assign occ_o     = occ_q;
endmodule

// File: rtl/stall_detect.sv
module stall_detect #(
    parameter int STALL_SLOTS = 64,
    localparam int CNT_W = $clog2(STALL_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             ack_i,
    input  logic             hold_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(STALL_SLOTS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             counting;

    assign counting = busy_i && !ack_i && !hold_i;
    assign fire_o   = counting && (cnt_q == LIMIT_M1);

    always_ff @(posedge clk) begin
        if (rst || !counting || fire_o) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/frame_pack.sv
module frame_pack
    import frame_tx_pkg::*;
(
    input  logic [PAY_W-1:0] pay_i,
    input  logic             is_link_i,
    input  logic             ack_i,
    output frame_t           frame_o
);
    always_comb begin
        frame_o = make_frame(pay_i, is_link_i, ack_i);
    end
endmodule

// File: rtl/frame_tx_replay.sv
module frame_tx_replay
    import frame_tx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int STALL_SLOTS = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(STALL_SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pay_valid_i,
    output logic               pay_ready_o,
    input  logic [PAY_W-1:0]   pay_data_i,
    input  logic               far_ack_i,
    input  logic               loc_ack_i,
    output logic [FRAME_W-1:0] frame_o
);
    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    rp_state_e        state_q;
    logic [PTR_W-1:0] rp_q;
    logic [OCC_W-1:0] rem_q;
    frame_t           frame_q, frame_d;

    logic [PTR_W-1:0] head;
    logic [OCC_W-1:0] occ;
    logic [PAY_W-1:0] rd_data;
    logic             fire, push;
    logic [CNT_W-1:0] stall_cnt;

    logic [PAY_W-1:0] sel_pay;
    logic             sel_link;

    assign pay_ready_o = (state_q == RP_IDLE) && !fire && (occ != FULL);
    assign push        = pay_valid_i && pay_ready_o;

    replay_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push),
        .push_data_i(pay_data_i),
        .retire_i   (far_ack_i),
        .rd_idx_i   (rp_q),
        .rd_data_o  (rd_data),
        .head_o     (head),
        .occ_o      (occ)
    );

    stall_detect #(.STALL_SLOTS(STALL_SLOTS)) u_stall (
        .clk   (clk),
        .rst   (rst),
        .busy_i(occ != '0),
        .ack_i (far_ack_i),
        .hold_i(state_q != RP_IDLE),
        .fire_o(fire),
        .cnt_o (stall_cnt)
    );

    always_comb begin
        sel_pay  = link_word(OP_PAUSE);
        sel_link = 1'b1;
        case (state_q)
            RP_MARK:   sel_pay = link_word(OP_REPLAY);
            RP_RESEND: begin
                sel_pay  = rd_data;
                sel_link = 1'b0;
            end
            default: begin
                if (push) begin
                    sel_pay  = pay_data_i;
                    sel_link = 1'b0;
                end
            end
        endcase
    end

    frame_pack u_pack (
        .pay_i    (sel_pay),
        .is_link_i(sel_link),
        .ack_i    (loc_ack_i),
        .frame_o  (frame_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RP_IDLE;
            rp_q    <= '0;
            rem_q   <= '0;
            frame_q <= make_frame(link_word(OP_PAUSE), 1'b1, 1'b0);
        end else begin
            frame_q <= frame_d;
            case (state_q)
                RP_IDLE: if (fire) begin
                    state_q <= RP_MARK;
                    rp_q    <= head;
                    rem_q   <= occ;
                end
                RP_MARK: state_q <= RP_RESEND;
                default: begin
                    rp_q  <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                    if (rem_q == OCC_W'(1)) state_q <= RP_IDLE;
                end
            endcase
        end
    end

    assign frame_o = frame_q;
endmodule

// File: rtl/frame_tx_replay_chk.sv
module frame_tx_replay_chk
    import frame_tx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int STALL_SLOTS = 64,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(STALL_SLOTS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               pay_valid_i,
    input logic               pay_ready_o,
    input logic               far_ack_i,
    input logic               loc_ack_i,
    input logic [FRAME_W-1:0] frame_o,
    input logic [OCC_W-1:0]   occ,
    input rp_state_e          state_q,
    input logic [CNT_W-1:0]   stall_cnt
);
    localparam logic [OCC_W-1:0] FULL  = OCC_W'(DEPTH);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STALL_SLOTS);

    frame_t f;
    assign f = frame_t'(frame_o);

    // R7
    full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL) |-> !pay_ready_o);

    // R10
    replay_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != RP_IDLE) |-> !pay_ready_o);

    // R9
    replay_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RP_MARK) |=> (f.is_link && f.payload[PAY_W-1 -: OP_W] == OP_REPLAY));

    // R8
    retire_chk: assert property (@(posedge clk) disable iff (rst)
        (far_ack_i && occ != '0 && !(pay_valid_i && pay_ready_o)) |=> (occ == $past(occ) - 1'b1));

    // R11
    stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stall_cnt < LIMIT);

    // R4
    link_op_chk: assert property (@(posedge clk) disable iff (rst)
        f.is_link |-> ((f.payload[PAY_W-1 -: OP_W] == OP_PAUSE ||
                        f.payload[PAY_W-1 -: OP_W] == OP_REPLAY) &&
                       f.payload[PAY_W-OP_W-1:0] == '0));

    // R6
    ack_bit_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (f.ack == $past(loc_ack_i)));
endmodule

bind frame_tx_replay frame_tx_replay_chk #(.DEPTH(DEPTH), .STALL_SLOTS(STALL_SLOTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pay_valid_i(pay_valid_i),
    .pay_ready_o(pay_ready_o),
    .far_ack_i  (far_ack_i),
    .loc_ack_i  (loc_ack_i),
    .frame_o    (frame_o),
    .occ        (occ),
    .state_q    (state_q),
    .stall_cnt  (stall_cnt)
);

// File: tb/frame_tx_replay_tb.sv
module frame_tx_replay_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pay_valid_i = 1'b0;
    logic        pay_ready_o;
    logic [71:0] pay_data_i = '0;
    logic        far_ack_i = 1'b0;
    logic        loc_ack_i = 1'b0;
    logic [79:0] frame_o;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    frame_tx_replay u_dut (
        .clk        (clk),
        .rst        (rst),
        .pay_valid_i(pay_valid_i),
        .pay_ready_o(pay_ready_o),
        .pay_data_i (pay_data_i),
        .far_ack_i  (far_ack_i),
        .loc_ack_i  (loc_ack_i),
        .frame_o    (frame_o)
    );

    function automatic logic [5:0] ref_crc(input logic [73:0] b);
        logic [5:0] c = 6'h3F;
        logic fb;
        for (int i = 73; i >= 0; i--) begin
            fb = c[5] ^ b[i];
            c  = {c[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
        end
        return c;
    endfunction

    function automatic logic [79:0] exp_frame(input logic [71:0] p, input logic lk, input logic ak);
        return {p, lk, ak, ref_crc({p, lk, ak})};
    endfunction

    function automatic logic [79:0] pause_f(input logic ak);
        return exp_frame({8'h00, 64'h0}, 1'b1, ak);
    endfunction

    function automatic logic [79:0] replay_f(input logic ak);
        return exp_frame({8'h01, 64'h0}, 1'b1, ak);
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [71:0] d, input logic fa, input logic la);
        pay_valid_i = v;
        pay_data_i  = d;
        far_ack_i   = fa;
        loc_ack_i   = la;
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [71:0] w [8];
        int n;
        for (int i = 0; i < 8; i++) w[i] = {9{8'(8'hA0 + i)}} ^ (72'h5 << (i * 7));

        // R1: reset state
        repeat (3) step(1'b0, '0, 1'b0, 1'b1);
        check("R1 reset frame", frame_o, pause_f(1'b0));
        check("R1 reset ready", {79'h0, pay_ready_o}, 80'h1);
        rst = 1'b0;

        // R2 R3 R6: single data frame with ack bit set
        step(1'b1, w[0], 1'b0, 1'b1);
        check("R2 R3 R6 data frame", frame_o, exp_frame(w[0], 1'b0, 1'b1));
        // R5: idle gives pause, R6 ack bit follows loc_ack_i
        step(1'b0, '0, 1'b0, 1'b0);
        check("R5 pause", frame_o, pause_f(1'b0));
        step(1'b0, '0, 1'b0, 1'b1);
        check("R6 pause ack", frame_o, pause_f(1'b1));
        step(1'b0, '0, 1'b1, 1'b0);

        // R2 R3 R6 sweep: shifted patterns, ack toggling, one frame in flight
        for (int i = 0; i < 24; i++) begin
            logic [71:0] d;
            d = {9{8'(i * 37 + 5)}} ^ (72'h1 << (i * 3));
            step(1'b1, d, (i > 0), i[0]);
            check("R3 sweep frame", frame_o, exp_frame(d, 1'b0, i[0]));
        end
        step(1'b0, '0, 1'b1, 1'b0);

        // R7: fill the store
        n = 0;
        for (int i = 0; i < 20; i++) begin
            pay_valid_i = 1'b1; pay_data_i = w[i % 8]; far_ack_i = 1'b0; loc_ack_i = 1'b0;
            #1;
            if (pay_ready_o) n++;
            @(posedge clk); #1;
        end
        check("R7 accepted count", 80'(n), 80'd16);
        check("R7 ready low when full", {79'h0, pay_ready_o}, 80'h0);
        // R8: one ack frees a place
        step(1'b0, '0, 1'b1, 1'b0);
        pay_valid_i = 1'b1; #1;
        check("R8 ready after ack", {79'h0, pay_ready_o}, 80'h1);
        pay_valid_i = 1'b0;
        for (int i = 0; i < 15; i++) step(1'b0, '0, 1'b1, 1'b0);
        // R8: acknowledges with nothing outstanding are ignored
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            pay_valid_i = 1'b1; pay_data_i = w[i % 8]; far_ack_i = 1'b0; loc_ack_i = 1'b0;
            #1;
            if (pay_ready_o) n++;
            @(posedge clk); #1;
        end
        check("R8 capacity after empty acks", 80'(n), 80'd16);
        for (int i = 0; i < 16; i++) step(1'b0, '0, 1'b1, 1'b0);

        // R9 R10: stall leads to replay of three frames
        for (int i = 0; i < 3; i++) step(1'b1, w[i], 1'b0, 1'b0);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b0, '0, 1'b0, 1'b0);
            if (frame_o === replay_f(1'b0)) break;
            if (frame_o === pause_f(1'b0)) n++;
        end
        check("R9 replay frame", frame_o, replay_f(1'b0));
        check("R9 pause slots before replay", 80'(n), 80'd62);
        check("R10 ready low at replay", {79'h0, pay_ready_o}, 80'h0);
        step(1'b1, w[3], 1'b0, 1'b0);
        check("R9 resend oldest", frame_o, exp_frame(w[0], 1'b0, 1'b0));
        check("R10 ready low in resend", {79'h0, pay_ready_o}, 80'h0);
        step(1'b1, w[3], 1'b0, 1'b0);
        check("R9 resend second", frame_o, exp_frame(w[1], 1'b0, 1'b0));
        check("R10 ready low in resend", {79'h0, pay_ready_o}, 80'h0);
        step(1'b1, w[3], 1'b0, 1'b0);
        check("R9 resend third", frame_o, exp_frame(w[2], 1'b0, 1'b0));
        step(1'b1, w[3], 1'b0, 1'b0);
        check("R10 new payload after resend", frame_o, exp_frame(w[3], 1'b0, 1'b0));
        step(1'b0, '0, 1'b0, 1'b0);
        check("R5 pause after replay", frame_o, pause_f(1'b0));
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b0);

        // R11: an acknowledge restarts the stall count
        step(1'b1, w[5], 1'b0, 1'b0);
        step(1'b1, w[6], 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) step(1'b0, '0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b0, '0, 1'b0, 1'b0);
            if (frame_o === replay_f(1'b0)) break;
            if (frame_o === pause_f(1'b0)) n++;
        end
        check("R11 slots after ack", 80'(n), 80'd64);
        step(1'b0, '0, 1'b0, 1'b1);
        check("R9 R11 resend remaining", frame_o, exp_frame(w[6], 1'b0, 1'b1));
        step(1'b0, '0, 1'b1, 1'b0);
        check("R5 pause at end", frame_o, pause_f(1'b0));

        summary();
    end
endmodule